// File: doc/BRIEF.md
# Paged Receive Buffer Controller

This block sits between a receive line decoder and a byte-wide packet buffer RAM. It takes the decoded bytes of one received frame and writes them into a host-selected page of the RAM. The bytes are stored in the layout the sender used, so a stored packet can be sent again with only its two ID bytes rewritten. A frame has two ID bytes, then a count byte, then the data. A non-zero count byte C marks a short packet of 256-C data bytes. When long packets are enabled, a zero count byte is followed by a second count byte C2, which marks a long packet of 512-C2 data bytes. The data bytes fill the page from offset C (or C2) up to its last byte. The block also outputs the decoded message length and a short/long flag.

A single `rx_inhibit` status bit controls which frames are accepted. The host issues an enable-receive command with a page number. That command clears the bit and selects the page for the next frame. The block sets the bit again only after a frame has arrived complete, with the right length and the good flag from the upstream CRC check. While the bit is set, new frames are refused. A level interrupt follows the bit through a mask input.

Top module: `rxbuf_ctrl`

## Requirements
- R1: After reset, `rx_inhibit` is 1, `ram_we` is 0, `msg_len` is 0 and `pkt_long` is 0.
- R2: A `cmd_rx_en` pulse makes `rx_inhibit` 0 on the next cycle and latches `cmd_page`. A frame started later writes to RAM address (page*256 + offset) modulo 2^RAM_AW.
- R3: A `rx_start` seen while `rx_inhibit` is 1 starts no frame, and none of that frame's bytes are written.
- R4: Each accepted byte appears on `ram_we`/`ram_addr`/`ram_wdata` one cycle after the cycle it is presented with `rx_valid`. Header bytes 0, 1 and 2 (source ID, destination ID, count) go to offsets 0, 1 and 2.
- R5: A non-zero count byte C sets `msg_len` to 256-C and `pkt_long` to 0. Data bytes are then written to offsets C, C+1, and so on.
- R6: With `cfg_long_en` at 1, a zero count byte makes byte 3 (value C2) go to offset 3. It sets `msg_len` to 512-C2 and `pkt_long` to 1, and data bytes are written from offset C2 upward.
- R7: With `cfg_long_en` at 0, a zero count byte drops the frame. Only offsets 0 to 2 are written and `rx_inhibit` stays 0.
- R8: `rx_inhibit` becomes 1 the cycle after `rx_end` only when `rx_good` is 1 and exactly `msg_len` data bytes arrived. `irq` equals `rx_inhibit` AND `irq_mask`.
- R9: A frame that has a bad flag, too few data bytes, or more than `msg_len` data bytes leaves `rx_inhibit` at 0. Bytes beyond `msg_len` are not written.
- R10: When `cmd_rx_en` coincides with a successful frame end, the command wins and `rx_inhibit` is 0.
- R11: A `rx_start` in the middle of a frame, with `rx_inhibit` at 0, restarts reception at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rx_en | input | 1 | Host enable-receive command pulse |
| cmd_page | input | RAM_AW-8 | Page number carried by the command |
| cfg_long_en | input | 1 | Long-packet reception enable |
| irq_mask | input | 1 | Interrupt mask for the receive-done bit |
| rx_start | input | 1 | Start of a received frame |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_end | input | 1 | End of frame |
| rx_good | input | 1 | CRC-good flag, sampled with rx_end |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_addr | output | RAM_AW | Buffer RAM byte address |
| ram_wdata | output | 8 | Buffer RAM write data |
| rx_inhibit | output | 1 | Receive-done / inhibit status bit |
| irq | output | 1 | Masked interrupt |
| msg_len | output | 10 | Decoded message length |
| pkt_long | output | 1 | Last decoded packet was long |

## Verification
The bench builds the block with RAM_AW = 10, which gives four pages. With that setting, a long packet placed on the last page runs past the top of the RAM. This makes the address wrap reachable, and it shows up in the shadow copy of the RAM. The other pages are enough to show that each page selection is kept separate from the previous one when frames are refused, dropped, overrun or restarted.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int OFF_W = 9;   // offset within a 512-byte window
  localparam int LEN_W = 10;  // message length up to 512

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_HDR,
    FS_DATA,
    FS_DROP
  } fstate_t;
endpackage

// File: rtl/rxbuf_frame_fsm.sv
module rxbuf_frame_fsm
  import rxbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inhibit,
  input  logic             long_en,
  input  logic             rx_start,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_end,
  input  logic             rx_good,
  output logic             start_ok,
  output logic             wr_fire,
  output logic [OFF_W-1:0] wr_off,
  output logic [7:0]       wr_data,
  output logic             frame_ok,
  output logic [LEN_W-1:0] len_q,
  output logic             long_q
);
  fstate_t          state_q, state_d;
  logic [1:0]       idx_q, idx_d;
  logic [OFF_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] len_d;
  logic             long_d;
  logic [LEN_W-1:0] byte_ext;

  assign byte_ext = LEN_W'(rx_data);
  assign wr_data  = rx_data;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    ptr_d    = ptr_q;
    rem_d    = rem_q;
    len_d    = len_q;
    long_d   = long_q;
    start_ok = 1'b0;
    wr_fire  = 1'b0;
    wr_off   = '0;
    frame_ok = 1'b0;
    if (rx_start) begin
      if (!inhibit) begin
        state_d  = FS_HDR;
        idx_d    = 2'd0;
        start_ok = 1'b1;
      end else begin
        state_d = FS_IDLE;
      end
    end else if (rx_end) begin
      if ((state_q == FS_DATA) && (rem_q == '0) && rx_good) begin
        frame_ok = 1'b1;
      end
      state_d = FS_IDLE;
    end else if (rx_valid) begin
      case (state_q)
        FS_HDR: begin
          wr_fire = 1'b1;
          wr_off  = OFF_W'(idx_q);
          if (idx_q < 2'd2) begin
            idx_d = idx_q + 2'd1;
          end else if (idx_q == 2'd2) begin
            if (rx_data != 8'h00) begin
              len_d   = LEN_W'(256) - byte_ext;
              rem_d   = LEN_W'(256) - byte_ext;
              ptr_d   = OFF_W'(rx_data);
              long_d  = 1'b0;
              state_d = FS_DATA;
            end else if (long_en) begin
              idx_d = 2'd3;
            end else begin
              state_d = FS_DROP;
            end
          end else begin
            len_d   = LEN_W'(512) - byte_ext;
            rem_d   = LEN_W'(512) - byte_ext;
            ptr_d   = OFF_W'(rx_data);
            long_d  = 1'b1;
            state_d = FS_DATA;
          end
        end
        FS_DATA: begin
          if (rem_q != '0) begin
            wr_fire = 1'b1;
            wr_off  = ptr_q;
            ptr_d   = ptr_q + OFF_W'(1);
            rem_d   = rem_q - LEN_W'(1);
          end else begin
            state_d = FS_DROP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= 2'd0;
      ptr_q   <= '0;
      rem_q   <= '0;
      len_q   <= '0;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      len_q   <= len_d;
      long_q  <= long_d;
    end
  end

  // R3
  inhibit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && inhibit) |=> (state_q == FS_IDLE));

  // R9
  no_excess_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == FS_DATA) && (rem_q == '0)) |-> !wr_fire);

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> ((state_q == FS_HDR) && (idx_q == 2'd0)));

  // R8
  done_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (state_q == FS_DATA));
endmodule

// File: rtl/rxbuf_wr_port.sv
module rxbuf_wr_port
  import rxbuf_pkg::*;
#(
  parameter int RAM_AW = 11,
  localparam int PG_W = RAM_AW - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic [PG_W-1:0]   page,
  input  logic              wr_fire,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [7:0]        wr_data,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  logic [PG_W-1:0]   fpage_q, fpage_d;
  logic [RAM_AW-1:0] base;
  logic [RAM_AW-1:0] addr_d, addr_q;
  logic [7:0]        data_d, data_q;
  logic              we_q;

  assign base    = {fpage_q, 8'h00};
  assign fpage_d = start_ok ? page : fpage_q;
  assign addr_d  = wr_fire ? (base + RAM_AW'(wr_off)) : addr_q;
  assign data_d  = wr_fire ? wr_data : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpage_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      fpage_q <= fpage_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      we_q    <= wr_fire;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = data_q;

  // R4
  wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (ram_we && (ram_wdata == $past(wr_data))));
endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status #(
  parameter int PG_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_rx_en,
  input  logic [PG_W-1:0] cmd_page,
  input  logic            frame_ok,
  input  logic            irq_mask,
  output logic            inhibit,
  output logic [PG_W-1:0] page,
  output logic            irq
);
  logic            inh_q, inh_d;
  logic [PG_W-1:0] page_q, page_d;

  always_comb begin
    inh_d  = inh_q;
    page_d = page_q;
    if (frame_ok) inh_d = 1'b1;
    if (cmd_rx_en) begin
      inh_d  = 1'b0;
      page_d = cmd_page;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q  <= 1'b1;
      page_q <= '0;
    end else begin
      inh_q  <= inh_d;
      page_q <= page_d;
    end
  end

  assign inhibit = inh_q;
  assign page    = page_q;
  assign irq     = inh_q & irq_mask;

  // R2
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_en |=> (!inh_q && (page_q == $past(cmd_page))));

  // R8
  set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inh_q) |-> $past(frame_ok));

  // R10
  cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rx_en && frame_ok) |=> !inh_q);
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int RAM_AW = 11,
  localparam int PG_W = RAM_AW - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rx_en,
  input  logic [PG_W-1:0]   cmd_page,
  input  logic              cfg_long_en,
  input  logic              irq_mask,
  input  logic              rx_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_end,
  input  logic              rx_good,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              rx_inhibit,
  output logic              irq,
  output logic [LEN_W-1:0]  msg_len,
  output logic              pkt_long
);
  logic             inhibit;
  logic [PG_W-1:0]  page;
  logic             start_ok;
  logic             wr_fire;
  logic [OFF_W-1:0] wr_off;
  logic [7:0]       wr_data;
  logic             frame_ok;

  rxbuf_status #(.PG_W(PG_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_rx_en (cmd_rx_en),
    .cmd_page  (cmd_page),
    .frame_ok  (frame_ok),
    .irq_mask  (irq_mask),
    .inhibit   (inhibit),
    .page      (page),
    .irq       (irq)
  );

  rxbuf_frame_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .inhibit  (inhibit),
    .long_en  (cfg_long_en),
    .rx_start (rx_start),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_end   (rx_end),
    .rx_good  (rx_good),
    .start_ok (start_ok),
    .wr_fire  (wr_fire),
    .wr_off   (wr_off),
    .wr_data  (wr_data),
    .frame_ok (frame_ok),
    .len_q    (msg_len),
    .long_q   (pkt_long)
  );

  rxbuf_wr_port #(.RAM_AW(RAM_AW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .page      (page),
    .wr_fire   (wr_fire),
    .wr_off    (wr_off),
    .wr_data   (wr_data),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  assign rx_inhibit = inhibit;

  // R3
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inhibit) && $past(rx_start)) |-> !ram_we);
endmodule

// File: tb/tb_rxbuf_ctrl.sv
module tb_rxbuf_ctrl;
  localparam int AW    = 10;
  localparam int PGW   = AW - 8;
  localparam int DEPTH = 1 << AW;

  logic           clk, rst_n;
  logic           cmd_rx_en;
  logic [PGW-1:0] cmd_page;
  logic           cfg_long_en, irq_mask;
  logic           rx_start, rx_valid, rx_end, rx_good;
  logic [7:0]     rx_data;
  logic           ram_we;
  logic [AW-1:0]  ram_addr;
  logic [7:0]     ram_wdata;
  logic           rx_inhibit, irq, pkt_long;
  logic [9:0]     msg_len;

  rxbuf_ctrl #(.RAM_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_rx_en(cmd_rx_en), .cmd_page(cmd_page),
    .cfg_long_en(cfg_long_en), .irq_mask(irq_mask), .rx_start(rx_start),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .rx_good(rx_good),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .rx_inhibit(rx_inhibit), .irq(irq), .msg_len(msg_len), .pkt_long(pkt_long)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp, n_bad, wcount;
  bit done;
  logic [7:0] mem [0:DEPTH-1];

  // behavioural reference state
  int e_ri, e_page, e_len, e_long, e_we, e_addr, e_data;
  int fpage, hdr_n, base, act, drop, ok_end;
  int q[$];

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic put(input int off, input int d);
    e_we = 1; e_addr = (fpage * 256 + off) % DEPTH; e_data = d;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      e_ri = 1; e_page = 0; e_len = 0; e_long = 0; e_we = 0; e_addr = 0; e_data = 0;
      act = 0; drop = 0; hdr_n = 0; q.delete();
    end else begin
      e_we = 0; ok_end = 0;
      if (rx_start) begin
        q.delete(); act = (e_ri == 0); drop = 0; hdr_n = 0; fpage = e_page;
      end else if (rx_end) begin
        if (act && !drop && hdr_n > 0 && (q.size() - hdr_n) == e_len && rx_good) ok_end = 1;
        act = 0;
      end else if (rx_valid && act && !drop) begin
        q.push_back(int'(rx_data));
        if (q.size() <= 3) begin
          put(q.size() - 1, rx_data);
          if (q.size() == 3) begin
            if (rx_data != 0) begin
              hdr_n = 3; e_len = 256 - rx_data; e_long = 0; base = rx_data;
            end else if (!cfg_long_en) drop = 1;
          end
        end else if (hdr_n == 0) begin
          put(3, rx_data); hdr_n = 4; e_len = 512 - rx_data; e_long = 1; base = rx_data;
        end else if ((q.size() - hdr_n) > e_len) begin
          drop = 1;
        end else begin
          put(base + q.size() - hdr_n - 1, rx_data);
        end
      end
      if (ok_end) e_ri = 1;
      if (cmd_rx_en) begin e_ri = 0; e_page = int'(cmd_page); end
    end
  end

  // per-clock comparison away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(rx_inhibit == e_ri[0], "R8 rx_inhibit", rx_inhibit, e_ri);
      chk(irq == (e_ri[0] & irq_mask), "R8 irq", irq, e_ri & irq_mask);
      chk(ram_we == e_we[0], "R4 ram_we", ram_we, e_we);
      if (e_we != 0) begin
        chk(ram_addr == AW'(e_addr), "R2 ram_addr", ram_addr, e_addr);
        chk(ram_wdata == e_data[7:0], "R4 ram_wdata", ram_wdata, e_data);
      end
      chk(msg_len == e_len[9:0], "R5 msg_len", msg_len, e_len);
      chk(pkt_long == e_long[0], "R6 pkt_long", pkt_long, e_long);
      if (ram_we) begin mem[ram_addr] = ram_wdata; wcount++; end
    end
  end

  task automatic cmd(input int pg);
    @(negedge clk); cmd_rx_en = 1; cmd_page = PGW'(pg);
    @(negedge clk); cmd_rx_en = 0;
  endtask

  task automatic send(input int b[$], input bit good, input bit cmd_at_end, input int pg);
    @(negedge clk); rx_start = 1;
    @(negedge clk); rx_start = 0;
    foreach (b[i]) begin
      rx_valid = 1; rx_data = b[i][7:0];
      @(negedge clk);
    end
    rx_valid = 0; rx_end = 1; rx_good = good;
    if (cmd_at_end) begin cmd_rx_en = 1; cmd_page = PGW'(pg); end
    @(negedge clk); rx_end = 0; cmd_rx_en = 0;
  endtask

  function automatic void mk(ref int f[$], input int sid, input int did, input int cnt,
                             input int cnt2, input int nd, input int seed);
    f.delete(); f.push_back(sid); f.push_back(did); f.push_back(cnt);
    if (cnt == 0) f.push_back(cnt2);
    for (int i = 0; i < nd; i++) f.push_back((seed + i * 7) & 255);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=0 expected=1");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int f[$];
    int w0;
    n_cmp = 0; n_bad = 0; wcount = 0; done = 0;
    rst_n = 0; cmd_rx_en = 0; cmd_page = '0; cfg_long_en = 0; irq_mask = 1;
    rx_start = 0; rx_valid = 0; rx_data = 0; rx_end = 0; rx_good = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rx_inhibit == 1'b1, "R1 inhibit", rx_inhibit, 1);
    chk(ram_we == 1'b0, "R1 ram_we", ram_we, 0);
    chk(msg_len == 10'd0, "R1 msg_len", msg_len, 0);
    chk(pkt_long == 1'b0, "R1 pkt_long", pkt_long, 0);

    // R3 frame refused while inhibited
    mk(f, 9, 8, 252, 0, 4, 1); w0 = wcount;
    send(f, 1, 0, 0);
    chk(wcount == w0, "R3 no writes", wcount - w0, 0);
    chk(rx_inhibit == 1'b1, "R3 inhibit held", rx_inhibit, 1);

    // R2/R5 short frame into page 1
    cmd(1);
    chk(rx_inhibit == 1'b0, "R2 cleared", rx_inhibit, 0);
    mk(f, 21, 22, 251, 0, 5, 40);
    send(f, 1, 0, 0);
    chk(rx_inhibit == 1'b1, "R8 set", rx_inhibit, 1);
    chk(mem[256] == 8'd21 && mem[257] == 8'd22 && mem[258] == 8'd251, "R4 header", mem[257], 22);
    for (int i = 0; i < 5; i++)
      chk(mem[256 + 251 + i] == 8'((40 + i * 7) & 255), "R5 data", mem[256 + 251 + i], (40 + i * 7) & 255);
    chk(msg_len == 10'd5, "R5 len", msg_len, 5);

    // R9 bad flag, then reuse page
    cmd(2);
    mk(f, 3, 4, 253, 0, 3, 9);
    send(f, 0, 0, 0);
    chk(rx_inhibit == 1'b0, "R9 bad flag", rx_inhibit, 0);
    mk(f, 5, 6, 254, 0, 2, 11);
    send(f, 1, 0, 0);
    chk(rx_inhibit == 1'b1, "R9 page reused", rx_inhibit, 1);

    // R7 zero count with long disabled
    cmd(0); w0 = wcount;
    mk(f, 1, 2, 0, 250, 6, 3);
    send(f, 1, 0, 0);
    chk(wcount - w0 == 3, "R7 three writes", wcount - w0, 3);
    chk(rx_inhibit == 1'b0, "R7 inhibit low", rx_inhibit, 0);

    // R6 long frame on the last page, wrapping past the top
    cfg_long_en = 1;
    cmd(3);
    mk(f, 31, 32, 0, 240, 272, 5);
    send(f, 1, 0, 0);
    chk(msg_len == 10'd272, "R6 len", msg_len, 272);
    chk(pkt_long == 1'b1, "R6 long flag", pkt_long, 1);
    chk(mem[768 + 3] == 8'd240, "R6 second count", mem[771], 240);
    chk(mem[(768 + 240) % DEPTH] == 8'd5, "R6 first data", mem[(768 + 240) % DEPTH], 5);
    chk(mem[(768 + 511) % DEPTH] == 8'((5 + 271 * 7) & 255), "R6 last data wraps",
        mem[(768 + 511) % DEPTH], (5 + 271 * 7) & 255);
    chk(rx_inhibit == 1'b1, "R6 done", rx_inhibit, 1);

    // R5 short frame with long enabled
    cmd(0);
    mk(f, 7, 7, 200, 0, 56, 2);
    send(f, 1, 0, 0);
    chk(pkt_long == 1'b0 && msg_len == 10'd56, "R5 short under long cfg", msg_len, 56);

    // R9 excess bytes and short data
    cmd(1); w0 = wcount;
    mk(f, 1, 1, 253, 0, 5, 77);
    send(f, 1, 0, 0);
    chk(wcount - w0 == 6, "R9 excess not written", wcount - w0, 6);
    chk(rx_inhibit == 1'b0, "R9 excess", rx_inhibit, 0);
    mk(f, 1, 1, 252, 0, 2, 66);
    send(f, 1, 0, 0);
    chk(rx_inhibit == 1'b0, "R9 short data", rx_inhibit, 0);

    // R10 command coincides with good end
    mk(f, 2, 2, 254, 0, 2, 1);
    send(f, 1, 1, 2);
    chk(rx_inhibit == 1'b0, "R10 command wins", rx_inhibit, 0);

    // R11 restart mid-frame
    @(negedge clk); rx_start = 1;
    @(negedge clk); rx_start = 0; rx_valid = 1; rx_data = 8'd99;
    @(negedge clk); rx_data = 8'd98;
    @(negedge clk); rx_valid = 0;
    mk(f, 44, 45, 254, 0, 2, 12);
    send(f, 1, 0, 0);
    chk(mem[512] == 8'd44, "R11 restart offset0", mem[512], 44);
    chk(rx_inhibit == 1'b1, "R11 done", rx_inhibit, 1);

    // R8 mask gates interrupt
    irq_mask = 0;
    @(negedge clk);
    chk(irq == 1'b0, "R8 masked irq", irq, 0);
    irq_mask = 1;
    @(negedge clk);
    chk(irq == 1'b1, "R8 unmasked irq", irq, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule